// File: doc/BRIEF.md
# Match and Capture Timer-Counter

This block is a 32-bit timer-counter with a word-addressed register port. It has two count sources. In timer mode a prescale counter divides the clock, and the main count advances once every (limit + 1) clocks. In counter mode the main count advances on chosen edges of one of the capture inputs. Four compare channels watch the count. On a hit, a channel can flag an interrupt, restart the count or halt counting, and it applies a programmed action to its own output pin.

Four capture channels copy the count into their own registers on the selected edges of their input pins. Every input pin passes through a two-flop synchroniser before edge detection. Hardware events set interrupt flags, software writes ones to clear them, and the single interrupt line is high whenever any flag is set. Software writes a register with `wr_en_i`, `addr_i` and `wdata_i`. It reads any register at any time on `rdata_o`, which is a combinational decode of `addr_i`.

Top module: `mct_timer`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and `ext_o` is 0. Word addresses: 0 control, 1 source select, 2 count, 3 prescale limit, 4 prescale count, 5 flags, 6 compare actions, 7 capture setup, 8 pin control, 9..12 compare values 0..3, 13..16 capture values 0..3. Unused addresses read 0.
- R2: In timer mode, while counting is enabled, the prescale count rises by one per clock. When it equals the limit it returns to 0 and the count advances, so the count steps once every limit+1 clocks. Both counters are writable.
- R3: Control bit 0 enables counting. While control bit 1 is set, the count and the prescale count are forced to 0 on every clock.
- R4: A compare hit on channel n happens at a count step when the count equals compare value n. If compare-action bit 3n is set, the hit sets flag bit n. `irq_o` is the OR of all flags. Writing 1 to a flag bit clears it, and a new event in the same cycle takes priority over the clear.
- R5: A hit on a channel whose compare-action bit 3n+1 is set loads 0 into the count at that step instead of incrementing it.
- R6: A hit on a channel whose compare-action bit 3n+2 is set clears control bit 0, and the count keeps its value at that step. A reset action on another channel still loads 0.
- R7: Pin control bits 2n+5:2n+4 give the action of pin n on a hit: 00 keep, 01 drive low, 10 drive high, 11 invert. Pin control bits 3:0 read and write the pin levels, and a write takes priority over a hit action in the same cycle.
- R8: Capture setup bit 3n selects rising edges and bit 3n+1 falling edges of input n. A selected edge copies the current count into capture value n. If bit 3n+2 is set, the edge also sets flag bit n+4. A pin change made before clock edge k is detected at edge k+2.
- R9: Source select bits 1:0 choose the source: 00 timer, 01 rising, 10 falling, 11 both edges. Bits 3:2 pick the input. In an edge mode the count steps once per selected synchronised edge, and the prescale count holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 5 | Register word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i |
| cap_i | input | 4 | Capture and count input pins |
| ext_o | output | 4 | Compare output pins |
| irq_o | output | 1 | Interrupt, OR of all flags |

## Verification
A register write takes effect at the next clock edge. A count step updates the count, the flags, the pin levels and the run bit at the same edge, so each of them can be read half a cycle later. `irq_o` follows the flags with no added delay. A change on `cap_i` reaches edge logic only at the second clock edge after it is driven. The bench's reference model takes one step at every rising edge, using the inputs that were driven on the previous falling edge. It compares `rdata_o`, `ext_o` and `irq_o` at the falling edge, where every one of those latencies has resolved.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int unsigned A_CTRL  = 0;
  localparam int unsigned A_SRC   = 1;
  localparam int unsigned A_COUNT = 2;
  localparam int unsigned A_PLIM  = 3;
  localparam int unsigned A_PCNT  = 4;
  localparam int unsigned A_FLAGS = 5;
  localparam int unsigned A_MACT  = 6;
  localparam int unsigned A_CSET  = 7;
  localparam int unsigned A_PINS  = 8;
  localparam int unsigned A_MVAL0 = 9;

  typedef enum logic [1:0] {
    SRC_TIMER = 2'b00,
    SRC_RISE  = 2'b01,
    SRC_FALL  = 2'b10,
    SRC_BOTH  = 2'b11
  } src_mode_e;

  typedef enum logic [1:0] {
    PIN_KEEP = 2'b00,
    PIN_LOW  = 2'b01,
    PIN_HIGH = 2'b10,
    PIN_FLIP = 2'b11
  } pin_act_e;
endpackage

// File: rtl/mct_in_sync.sv
module mct_in_sync #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic s1_q, s2_q, s3_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= 1'b0;
        s2_q <= 1'b0;
        s3_q <= 1'b0;
      end else begin
        s1_q <= d_i[g];
        s2_q <= s1_q;
        s3_q <= s2_q;
      end
    end
    assign rise_o[g] = s2_q & ~s3_q;
    assign fall_o[g] = ~s2_q & s3_q;

    assert_edge_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(rise_o[g] && fall_o[g]))
      else $error("edge flags overlap");
  end
endmodule

// File: rtl/mct_prescale.sv
module mct_prescale #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] lim_i,
  output logic [W-1:0] cnt_o,
  output logic         wrap_o
);
  logic [W-1:0] cnt_q;

  assign wrap_o = run_i && (cnt_q == lim_i);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (wr_i)   cnt_q <= wdata_i;
    else if (wrap_o) cnt_q <= '0;
    else if (run_i)  cnt_q <= cnt_q + 1'b1;
  end

  assert_wrap_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wrap_o && !wr_i) |=> (cnt_o == '0))
    else $error("prescale did not wrap");
endmodule

// File: rtl/mct_match_ch.sv
module mct_match_ch
  import mct_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] val_i,
  input  logic [1:0]   act_i,
  input  logic         pin_wr_i,
  input  logic         pin_wd_i,
  output logic         hit_o,
  output logic         pin_o
);
  logic pin_q;

  assign hit_o = tick_i && (cnt_i == val_i);
  assign pin_o = pin_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pin_q <= 1'b0;
    else if (pin_wr_i) pin_q <= pin_wd_i;
    else if (hit_o) begin
      unique case (pin_act_e'(act_i))
        PIN_LOW:  pin_q <= 1'b0;
        PIN_HIGH: pin_q <= 1'b1;
        PIN_FLIP: pin_q <= ~pin_q;
        default:  pin_q <= pin_q;
      endcase
    end
  end

  assert_pin_flip_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !pin_wr_i && act_i == 2'b11) |=> (pin_o != $past(pin_o)))
    else $error("pin did not invert");
  assert_pin_high_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !pin_wr_i && act_i == 2'b10) |=> pin_o)
    else $error("pin not driven high");
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned N_CH   = 4,
  parameter int unsigned ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [CNT_W-1:0]  wdata_i,
  output logic [CNT_W-1:0]  rdata_o,
  input  logic [N_CH-1:0]   cap_i,
  output logic [N_CH-1:0]   ext_o,
  output logic              irq_o
);
  localparam int unsigned SEL_W   = (N_CH > 1) ? $clog2(N_CH) : 1;
  localparam int unsigned SRC_W   = 2 + SEL_W;
  localparam int unsigned ACT3_W  = 3 * N_CH;
  localparam int unsigned PACT_W  = 2 * N_CH;
  localparam int unsigned FLAG_W  = 2 * N_CH;
  localparam int unsigned CAP0    = A_MVAL0 + N_CH;

  logic                 en_q, clr_q;
  logic [SRC_W-1:0]     src_q;
  logic [CNT_W-1:0]     cnt_q, plim_q, pcnt;
  logic [ACT3_W-1:0]    mact_q, cset_q;
  logic [PACT_W-1:0]    pact_q;
  logic [FLAG_W-1:0]    flags_q, flag_set;
  logic [CNT_W-1:0]     mval_q [N_CH];
  logic [CNT_W-1:0]     capv_q [N_CH];
  logic [N_CH-1:0]      rise, fall, hit, cap_ev;
  logic [N_CH-1:0]      hit_rst, hit_stop, hit_irq, cap_irq;
  logic                 wr_ctrl, wr_src, wr_cnt, wr_plim, wr_pcnt, wr_flags;
  logic                 wr_mact, wr_cset, wr_pins;
  logic                 timer_mode, pre_run, pre_wrap, edge_sel, tick;
  logic                 any_rst, any_stop;
  logic [SEL_W-1:0]     sel;

  assign wr_ctrl  = wr_en_i && (addr_i == ADDR_W'(A_CTRL));
  assign wr_src   = wr_en_i && (addr_i == ADDR_W'(A_SRC));
  assign wr_cnt   = wr_en_i && (addr_i == ADDR_W'(A_COUNT));
  assign wr_plim  = wr_en_i && (addr_i == ADDR_W'(A_PLIM));
  assign wr_pcnt  = wr_en_i && (addr_i == ADDR_W'(A_PCNT));
  assign wr_flags = wr_en_i && (addr_i == ADDR_W'(A_FLAGS));
  assign wr_mact  = wr_en_i && (addr_i == ADDR_W'(A_MACT));
  assign wr_cset  = wr_en_i && (addr_i == ADDR_W'(A_CSET));
  assign wr_pins  = wr_en_i && (addr_i == ADDR_W'(A_PINS));

  mct_in_sync #(.N(N_CH)) u_sync (
    .clk_i, .rst_ni, .d_i(cap_i), .rise_o(rise), .fall_o(fall)
  );

  assign timer_mode = (src_mode_e'(src_q[1:0]) == SRC_TIMER);
  assign sel        = src_q[SRC_W-1:2];
  assign pre_run    = en_q && !clr_q && timer_mode;

  mct_prescale #(.W(CNT_W)) u_pre (
    .clk_i, .rst_ni, .run_i(pre_run), .clr_i(clr_q), .wr_i(wr_pcnt),
    .wdata_i(wdata_i), .lim_i(plim_q), .cnt_o(pcnt), .wrap_o(pre_wrap)
  );

  always_comb begin
    unique case (src_mode_e'(src_q[1:0]))
      SRC_RISE: edge_sel = rise[sel];
      SRC_FALL: edge_sel = fall[sel];
      SRC_BOTH: edge_sel = rise[sel] | fall[sel];
      default:  edge_sel = pre_wrap;
    endcase
  end
  assign tick = en_q && !clr_q && edge_sel;

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    mct_match_ch #(.W(CNT_W)) u_match (
      .clk_i, .rst_ni, .tick_i(tick), .cnt_i(cnt_q), .val_i(mval_q[g]),
      .act_i(pact_q[2*g +: 2]), .pin_wr_i(wr_pins), .pin_wd_i(wdata_i[g]),
      .hit_o(hit[g]), .pin_o(ext_o[g])
    );
    assign hit_irq[g]  = hit[g] & mact_q[3*g];
    assign hit_rst[g]  = hit[g] & mact_q[3*g+1];
    assign hit_stop[g] = hit[g] & mact_q[3*g+2];
    assign cap_ev[g]   = (rise[g] & cset_q[3*g]) | (fall[g] & cset_q[3*g+1]);
    assign cap_irq[g]  = cap_ev[g] & cset_q[3*g+2];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mval_q[g] <= '0;
        capv_q[g] <= '0;
      end else begin
        if (wr_en_i && addr_i == ADDR_W'(A_MVAL0 + g)) mval_q[g] <= wdata_i;
        if (cap_ev[g]) capv_q[g] <= cnt_q;
      end
    end

    assert_cap_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cap_irq[g] |=> flags_q[N_CH+g])
      else $error("capture flag missing");
  end

  assign any_rst  = |hit_rst;
  assign any_stop = |hit_stop;
  assign flag_set = {cap_irq, hit_irq};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      clr_q   <= 1'b0;
      src_q   <= '0;
      cnt_q   <= '0;
      plim_q  <= '0;
      mact_q  <= '0;
      cset_q  <= '0;
      pact_q  <= '0;
      flags_q <= '0;
    end else begin
      if (wr_ctrl) begin
        en_q  <= wdata_i[0];
        clr_q <= wdata_i[1];
      end else if (tick && any_stop) begin
        en_q <= 1'b0;
      end
      if (clr_q)       cnt_q <= '0;
      else if (wr_cnt) cnt_q <= wdata_i;
      else if (tick) begin
        if (any_rst)       cnt_q <= '0;
        else if (!any_stop) cnt_q <= cnt_q + 1'b1;
      end
      if (wr_src)  src_q  <= wdata_i[SRC_W-1:0];
      if (wr_plim) plim_q <= wdata_i;
      if (wr_mact) mact_q <= wdata_i[ACT3_W-1:0];
      if (wr_cset) cset_q <= wdata_i[ACT3_W-1:0];
      if (wr_pins) pact_q <= wdata_i[N_CH +: PACT_W];
      flags_q <= (flags_q & ~(wr_flags ? wdata_i[FLAG_W-1:0] : '0)) | flag_set;
    end
  end

  assign irq_o = |flags_q;

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      ADDR_W'(A_CTRL):  rdata_o = CNT_W'({clr_q, en_q});
      ADDR_W'(A_SRC):   rdata_o = CNT_W'(src_q);
      ADDR_W'(A_COUNT): rdata_o = cnt_q;
      ADDR_W'(A_PLIM):  rdata_o = plim_q;
      ADDR_W'(A_PCNT):  rdata_o = pcnt;
      ADDR_W'(A_FLAGS): rdata_o = CNT_W'(flags_q);
      ADDR_W'(A_MACT):  rdata_o = CNT_W'(mact_q);
      ADDR_W'(A_CSET):  rdata_o = CNT_W'(cset_q);
      ADDR_W'(A_PINS):  rdata_o = CNT_W'({pact_q, ext_o});
      default: begin
        for (int k = 0; k < N_CH; k++) begin
          if (addr_i == ADDR_W'(A_MVAL0 + k)) rdata_o = mval_q[k];
          if (addr_i == ADDR_W'(CAP0 + k))    rdata_o = capv_q[k];
        end
      end
    endcase
  end

  assert_clr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_q |=> (cnt_q == '0 && pcnt == '0))
    else $error("hold-clear ignored");
  assert_irq_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_o) |-> $past(|flag_set))
    else $error("irq without event");
  assert_match_rst_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_rst && !wr_cnt) |=> (cnt_q == '0))
    else $error("match reset missed");
  assert_match_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_stop && !wr_ctrl) |=> !en_q)
    else $error("match stop missed");
endmodule

// File: tb/mct_timer_tb_top.sv
module mct_timer_tb_top;
  localparam int CLK_P = 10;
  localparam int WDOG  = 20000;

  logic        clk = 1'b0, rst_n = 1'b0, wr = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [3:0]  cap = '0;
  logic [31:0] rdata;
  logic [3:0]  ext;
  logic        irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  mct_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .cap_i(cap), .ext_o(ext), .irq_o(irq)
  );

  // reference model state
  logic        m_en = 0, m_clr = 0;
  logic [3:0]  m_src = 0, m_pin = 0, m_s1 = 0, m_s2 = 0, m_s3 = 0;
  logic [31:0] m_tc = 0, m_pc = 0, m_pr = 0;
  logic [11:0] m_mact = 0, m_cset = 0;
  logic [7:0]  m_pact = 0, m_fl = 0;
  logic [31:0] m_mv [4] = '{default: 0};
  logic [31:0] m_cv [4] = '{default: 0};

  function automatic logic [31:0] m_read(input logic [4:0] a);
    case (a)
      0: return {30'b0, m_clr, m_en};
      1: return {28'b0, m_src};
      2: return m_tc;
      3: return m_pr;
      4: return m_pc;
      5: return {24'b0, m_fl};
      6: return {20'b0, m_mact};
      7: return {20'b0, m_cset};
      8: return {20'b0, m_pact, m_pin};
      9, 10, 11, 12: return m_mv[a-9];
      13, 14, 15, 16: return m_cv[a-13];
      default: return 32'b0;
    endcase
  endfunction

  function automatic string req_of(input logic [4:0] a);
    case (a)
      0: return "R3";  1: return "R9";  2, 3, 4: return "R2";
      5: return "R4";  6: return "R5";  7: return "R8";  8: return "R7";
      9, 10, 11, 12: return "R4";
      13, 14, 15, 16: return "R8";
      default: return "R1";
    endcase
  endfunction

  task automatic model_step();
    logic [3:0] rs, fl, hit;
    logic tick, a_rst, a_stop, n_en, n_clr;
    logic [31:0] n_tc, n_pc;
    logic [7:0] setf, n_fl;
    logic [3:0] n_pin;
    logic [1:0] md;
    int sel;
    rs = m_s2 & ~m_s3;
    fl = ~m_s2 & m_s3;
    md = m_src[1:0];
    sel = int'(m_src[3:2]);
    tick = 0; n_pc = m_pc;
    if (m_en && !m_clr) begin
      if (md == 0) begin
        if (m_pc == m_pr) begin n_pc = 0; tick = 1; end
        else n_pc = m_pc + 1;
      end else if (md == 1) tick = rs[sel];
      else if (md == 2) tick = fl[sel];
      else tick = rs[sel] | fl[sel];
    end
    a_rst = 0; a_stop = 0; setf = 0; n_pin = m_pin;
    for (int k = 0; k < 4; k++) begin
      hit[k] = tick && (m_tc == m_mv[k]);
      if (hit[k]) begin
        if (m_mact[3*k])   setf[k] = 1;
        if (m_mact[3*k+1]) a_rst = 1;
        if (m_mact[3*k+2]) a_stop = 1;
        case (m_pact[2*k +: 2])
          2'b01: n_pin[k] = 0;
          2'b10: n_pin[k] = 1;
          2'b11: n_pin[k] = ~m_pin[k];
          default: ;
        endcase
      end
    end
    n_tc = m_tc;
    if (tick) n_tc = a_rst ? 0 : (a_stop ? m_tc : m_tc + 1);
    n_en = m_en && !(tick && a_stop);
    n_clr = m_clr;
    for (int k = 0; k < 4; k++) begin
      if ((rs[k] && m_cset[3*k]) || (fl[k] && m_cset[3*k+1])) begin
        m_cv[k] = m_tc;
        if (m_cset[3*k+2]) setf[k+4] = 1;
      end
    end
    n_fl = m_fl;
    if (wr) begin
      case (addr)
        0: begin n_en = wdata[0]; n_clr = wdata[1]; end
        1: m_src = wdata[3:0];
        2: n_tc = wdata;
        3: m_pr = wdata;
        4: n_pc = wdata;
        5: n_fl = n_fl & ~wdata[7:0];
        6: m_mact = wdata[11:0];
        7: m_cset = wdata[11:0];
        8: begin n_pin = wdata[3:0]; m_pact = wdata[11:4]; end
        9, 10, 11, 12: m_mv[addr-9] = wdata;
        default: ;
      endcase
    end
    n_fl = n_fl | setf;
    if (m_clr) begin n_tc = 0; n_pc = 0; end
    m_en = n_en; m_clr = n_clr; m_tc = n_tc; m_pc = n_pc; m_fl = n_fl; m_pin = n_pin;
    m_s3 = m_s2; m_s2 = m_s1; m_s1 = cap;
  endtask

  task automatic chk(input string r, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", r, what, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      chk(req_of(addr), "rdata", rdata, m_read(addr));
      chk("R4", "irq_o", {31'b0, irq}, {31'b0, |m_fl});
      chk("R7", "ext_o", {28'b0, ext}, {28'b0, m_pin});
    end
  endtask

  task automatic wr_reg(input logic [4:0] a, input logic [31:0] d);
    logic [4:0] keep;
    keep = addr;
    wr = 1; addr = a; wdata = d;
    cyc();
    wr = 0; addr = keep;
  endtask

  task automatic flip(input int k, input int gap);
    cap[k] = ~cap[k];
    cyc(gap);
  endtask

  task automatic sweep();
    for (int a = 0; a < 18; a++) begin addr = 5'(a); cyc(); end
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk("R1", "irq_o in reset", {31'b0, irq}, 32'b0);
    rst_n = 1;
    // R1: reset values over the whole map
    sweep();
    // R2 R4 R5: prescale 2, channel 0 flags and restarts at 4
    wr_reg(3, 2);
    wr_reg(9, 4);
    wr_reg(6, 32'h003);
    addr = 2;
    wr_reg(0, 1);
    cyc(30);
    addr = 4; cyc(5);
    addr = 5; cyc(2);
    wr_reg(5, 32'h1);          // R4 write-one-to-clear
    cyc(3);
    // R6: stop on channel 1 at 6
    wr_reg(0, 2); wr_reg(0, 0);
    wr_reg(3, 0); wr_reg(10, 6); wr_reg(6, 32'h020);
    addr = 2; wr_reg(0, 1);
    cyc(12);
    addr = 0; cyc(2);
    addr = 2; cyc(2);
    // R7: ch0 invert, ch1 high, ch2 low, pin2 preset high
    wr_reg(0, 2); wr_reg(0, 0);
    wr_reg(8, 32'h1B4);
    wr_reg(9, 4); wr_reg(10, 1); wr_reg(11, 2);
    wr_reg(6, 32'h002);
    addr = 8; wr_reg(0, 1);
    cyc(25);
    wr_reg(8, 32'h00A);        // R7 pin write
    cyc(3);
    // R8: ch0 rise+irq, ch1 fall+irq, ch3 both edges
    wr_reg(6, 0); wr_reg(5, 32'hFF);
    wr_reg(7, 32'h635);
    addr = 13;
    flip(0, 4); flip(1, 5); flip(1, 6); flip(0, 3); flip(3, 4); flip(3, 5);
    addr = 5; cyc(1);
    sweep();
    wr_reg(5, 32'hF0);
    // R9: count edges of input 2
    wr_reg(7, 0);
    wr_reg(0, 2); wr_reg(0, 0);
    wr_reg(1, 32'h9);
    addr = 2; wr_reg(0, 1);
    for (int i = 0; i < 6; i++) flip(2, 3);
    wr_reg(1, 32'hB);
    for (int i = 0; i < 6; i++) flip(2, 2);
    wr_reg(1, 32'hA);
    for (int i = 0; i < 4; i++) flip(2, 4);
    flip(1, 3);                // other input: no step
    addr = 4; cyc(2);
    // R3: hold-clear while enabled
    wr_reg(1, 0); wr_reg(3, 1);
    addr = 2; cyc(6);
    wr_reg(0, 3);
    cyc(5);
    addr = 4; cyc(2);
    wr_reg(0, 1);
    addr = 2; cyc(8);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule